// File: doc/BRIEF.md
# Carry-Chained ALU with Compare

A combinational 16-bit arithmetic and logic unit for a small processor core. One 4-bit function code selects among addition, subtraction, bitwise logic, three shifts and six comparisons. The left operand is the destination register's value and the right operand is the already selected right-hand value, which comes from a register or an immediate. A carry-in lets multi-word additions and subtractions chain across instructions. The flag register that holds the carry between instructions sits outside this block, as does the flag that records a pending skip.

Arithmetic and logic functions produce a 16-bit result and raise a write-enable. Only the two chaining functions report a carry-out, which is bit 16 of the widened operation. Comparisons write nothing. They drive a condition output instead. The surrounding core skips the next instruction when that output is low, so the skip flag is the inverse of the comparison.

Top module: `carry_alu`

## Requirements
- R1: Codes 0 and 2 give result = (lhs + rhs + cin) mod 2^16.
- R2: Codes 1 and 3 give result = (lhs - rhs - cin) mod 2^16, with cin acting as a borrow.
- R3: cout is 1 only for code 2 when lhs + rhs + cin >= 2^16, and only for code 3 when lhs < rhs + cin. For every other code cout is 0.
- R4: Code 4 gives lhs XOR rhs, code 5 gives lhs AND rhs, and code 6 gives lhs OR rhs.
- R5: For shift amounts rhs from 0 to 15, code 7 gives lhs shifted left with zero fill, and code 8 gives lhs shifted right with zero fill.
- R6: For shift amounts rhs from 0 to 15, code 9 gives lhs shifted right with copies of bit 15 filling from the top.
- R7: When rhs >= 16, codes 7 and 8 give 0, and code 9 gives 0xFFFF if lhs bit 15 is set and 0 otherwise.
- R8: cond_true reports the comparison for each compare code: 10 is lhs == rhs, 11 is lhs != rhs, 12 is signed lhs < rhs, 13 is signed lhs >= rhs, 14 is unsigned lhs < rhs, and 15 is unsigned lhs >= rhs.
- R9: For codes 10 to 15, wr_en is 0, result is 0 and cout is 0.
- R10: For codes 0 to 9, wr_en is 1 and cond_true is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func | input | 4 | Function code |
| lhs | input | 16 | Left operand (destination register value) |
| rhs | input | 16 | Right operand (register or immediate value) |
| cin | input | 1 | Carry or borrow in from the previous chaining instruction |
| result | output | 16 | Function result |
| cout | output | 1 | Carry or borrow out, valid only for the chaining codes |
| cond_true | output | 1 | Comparison outcome for the compare codes |
| wr_en | output | 1 | Result should be written back |

## Verification
The hardest cases to reach are the ones where the carry-in decides the outcome alone. Examples are 0xFFFF + 0 + 1 wrapping to zero with a carry, and 0 - 0 - 1 borrowing. The operand set therefore includes both extremes and their neighbours, and every pairing is driven with cin at 0 and at 1. The sign-boundary values 0x7FFF, 0x8000 and 0x8001 separate the signed compares from the unsigned ones. Right operands from 16 upward, including 0xFFFF, exercise the shift saturation.

// File: rtl/carry_alu.sv
module carry_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   func,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         cin,
  output logic [W-1:0] result,
  output logic         cout,
  output logic         cond_true,
  output logic         wr_en
);
  localparam int SW = $clog2(W);

  logic [W:0]    sum, dif;
  logic [SW-1:0] sh;
  logic          wide;
  logic [W-1:0]  shl_v, shr_v, asr_v;

  assign sum  = {1'b0, lhs} + {1'b0, rhs} + (W+1)'(cin);
  assign dif  = {1'b0, lhs} - {1'b0, rhs} - (W+1)'(cin);
  assign sh   = rhs[SW-1:0];
  assign wide = |rhs[W-1:SW];

  assign shl_v = wide ? '0 : lhs << sh;
  assign shr_v = wide ? '0 : lhs >> sh;
  assign asr_v = wide ? {W{lhs[W-1]}} : W'($signed(lhs) >>> sh);

  always_comb begin
    result    = '0;
    cout      = 1'b0;
    cond_true = 1'b0;
    wr_en     = 1'b1;
    case (func)
      4'd0:  result = sum[W-1:0];
      4'd1:  result = dif[W-1:0];
      4'd2:  begin result = sum[W-1:0]; cout = sum[W]; end
      4'd3:  begin result = dif[W-1:0]; cout = dif[W]; end
      4'd4:  result = lhs ^ rhs;
      4'd5:  result = lhs & rhs;
      4'd6:  result = lhs | rhs;
      4'd7:  result = shl_v;
      4'd8:  result = shr_v;
      4'd9:  result = asr_v;
      default: begin
        wr_en = 1'b0;
        case (func)
          4'd10:   cond_true = (lhs == rhs);
          4'd11:   cond_true = (lhs != rhs);
          4'd12:   cond_true = ($signed(lhs) <  $signed(rhs));
          4'd13:   cond_true = ($signed(lhs) >= $signed(rhs));
          4'd14:   cond_true = (lhs <  rhs);
          default: cond_true = (lhs >= rhs);
        endcase
      end
    endcase
  end
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
  parameter int W = 16
) (
  input logic [3:0]   func,
  input logic [W-1:0] lhs,
  input logic [W-1:0] rhs,
  input logic         cin,
  input logic [W-1:0] result,
  input logic         cout,
  input logic         cond_true,
  input logic         wr_en
);
  always_comb begin
    AST_ADD_SUM: assert (!(func == 4'd0 || func == 4'd2) || result == lhs + rhs + W'(cin)); // R1
    AST_SUB_UNDO: assert (!(func == 4'd1 || func == 4'd3) || result + rhs + W'(cin) == lhs); // R2
    AST_CARRY_CHAIN_ONLY: assert ((func == 4'd2 || func == 4'd3) || !cout); // R3
    AST_XOR_UNDO: assert (func != 4'd4 || (result ^ rhs) == lhs); // R4
    AST_WIDE_SHIFT_ZERO: assert (!((func == 4'd7 || func == 4'd8) && rhs >= W[W-1:0]) || result == '0); // R7
    AST_CMP_NO_WRITE: assert (func < 4'd10 || (!wr_en && result == '0)); // R9
    AST_NONCMP_WRITES: assert (func >= 4'd10 || (wr_en && !cond_true)); // R10
  end
endmodule

bind carry_alu carry_alu_chk #(.W(W)) u_chk (.*);

// File: tb/test_carry_alu.sv
module test_carry_alu;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic [3:0]  func;
  logic [15:0] lhs, rhs;
  logic        cin;
  logic [15:0] result;
  logic        cout, cond_true, wr_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  carry_alu i_carry_alu (.func(func), .lhs(lhs), .rhs(rhs), .cin(cin),
    .result(result), .cout(cout), .cond_true(cond_true), .wr_en(wr_en));

  function automatic int opval(int i);
    case (i)
      0: return 0;       1: return 1;       2: return 2;       3: return 3;
      4: return 7;       5: return 15;      6: return 16;      7: return 17;
      8: return 'h7FFF;  9: return 'h8000;  10: return 'h8001; 11: return 'hFFFF;
      12: return 'hFFFE; 13: return 'h00FF; 14: return 'hFF00; 15: return 'h5555;
      16: return 'hAAAA; 17: return 'h1234; 18: return 'hFEDC; 19: return 31;
      20: return 8;      21: return 4;      22: return 'h4000; default: return 'hC000;
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s func=%0d lhs=%h rhs=%h cin=%0d actual=%h expected=%h",
               req, func, lhs, rhs, cin, got, exp);
    end
  endtask

  initial begin
    func = 0; lhs = 0; rhs = 0; cin = 0;
    @(negedge clk);
    check("R1 idle result", int'(result), 0);
    check("R10 idle wr_en", int'(wr_en), 1);
    for (int f = 0; f < 16; f++)
      for (int a = 0; a < 24; a++)
        for (int b = 0; b < 24; b++)
          for (int c = 0; c < 2; c++) begin
            int av, bv, er, ec, et, t;
            string req;
            av = opval(a); bv = opval(b);
            @(posedge clk); #1;
            func = 4'(f); lhs = 16'(av); rhs = 16'(bv); cin = c[0];
            er = 0; ec = 0; et = 0;
            case (f)
              0, 2: begin t = av + bv + c; er = t % 65536; ec = (f == 2 && t >= 65536); req = (f == 0) ? "R1" : "R3"; end
              1, 3: begin t = av - bv - c; er = (t + 65536) % 65536; ec = (f == 3 && t < 0); req = (f == 1) ? "R2" : "R3"; end
              4: begin er = av ^ bv; req = "R4"; end
              5: begin er = av & bv; req = "R4"; end
              6: begin er = av | bv; req = "R4"; end
              7: begin er = (bv < 16) ? (av * (1 << bv)) % 65536 : 0; req = (bv < 16) ? "R5" : "R7"; end
              8: begin er = (bv < 16) ? av / (1 << bv) : 0; req = (bv < 16) ? "R5" : "R7"; end
              9: begin
                   if (bv < 16) begin
                     t = sgn(av) >>> bv; er = t & 'hFFFF; req = "R6";
                   end else begin
                     er = (av >= 32768) ? 'hFFFF : 0; req = "R7";
                   end
                 end
              10: begin et = (av == bv); req = "R8"; end
              11: begin et = (av != bv); req = "R8"; end
              12: begin et = (sgn(av) < sgn(bv)); req = "R8"; end
              13: begin et = (sgn(av) >= sgn(bv)); req = "R8"; end
              14: begin et = (av < bv); req = "R8"; end
              default: begin et = (av >= bv); req = "R8"; end
            endcase
            @(negedge clk);
            check((f >= 10) ? "R9 result" : req, int'(result), er);
            check((f >= 10) ? "R9 cout" : "R3 cout", int'(cout), ec);
            check((f >= 10) ? req : "R10 cond_true", int'(cond_true), et);
            check((f >= 10) ? "R9 wr_en" : "R10 wr_en", int'(wr_en), (f < 10) ? 1 : 0);
          end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule